// File: doc/BRIEF.md
# Filter-Paced Parallel DAC Write Sequencer

This block takes the output stream of a digital filter and turns each result word into one write cycle on a parallel-input DAC. It runs on the same clock as the filter, so the filter's single-cycle valid strobe is sampled on every rising edge and cannot be missed. Writes are started only by real output samples. No free-running rate counter sets the pace, so the DAC update rate always follows the filter's output rate.

When a valid word arrives while the sequencer is idle, the block takes a 12-bit slice from the upper end of the 32-bit filter result and puts it on the DAC bus. It pulls chip select and write enable low together. Write enable stays low for a set number of cycles, then rises while chip select is still low, which gives the DAC data hold time. Chip select rises one cycle later and the block goes back to idle.

A valid strobe that comes while a write is still in progress is discarded, and a sticky overrun flag records the loss. Only reset clears that flag.

Top module: `dac_write_seq`

## Requirements
- R1: While reset is asserted and after it is released, chip select and write enable read 1, the DAC bus reads 0 and the overrun flag reads 0.
- R2: If the valid input is 1 at a rising edge while the block is idle (chip select high), chip select and write enable are both 0 right after that edge.
- R3: The value driven on the DAC bus at the start of a write equals input bits 31 down to 20 of the word presented with the accepted valid.
- R4: Write enable stays 0 for exactly WE_LOW clock cycles (default 2). It then rises to 1 while chip select is still 0.
- R5: Chip select rises to 1 exactly one cycle after write enable rises.
- R6: The DAC bus holds the same value for the whole time chip select is 0.
- R7: Chip select and write enable never fall unless the valid input was 1 at the preceding edge. With valid held at 0, no write occurs.
- R8: A valid input that is 1 at an edge while chip select is 0 does not change the DAC bus or lengthen the write, and it sets the overrun flag to 1.
- R9: A valid input sampled at the first edge after chip select has risen starts a new write.
- R10: Once set, the overrun flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared filter and sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new filter result |
| smp_data | input | 32 | Filter result word |
| dac_bus | output | 12 | Parallel DAC data |
| dac_cs_n | output | 1 | Active-low DAC chip select |
| dac_we_n | output | 1 | Active-low DAC write enable |
| ovr_flag | output | 1 | Sticky flag: a valid strobe was dropped during a write |

## Verification
A wrong strobe state, such as a stuck or miscounted cycle counter, shows at the pins within one cycle as a write-enable pulse of the wrong width or a chip-select rise at the wrong time. A corrupted data register shows on the bus during the same write. A mistaken busy decision shows in the next cycle in one of two ways: as an extra write started by a strobe that should have been dropped, or as a missing overrun flag. Because every output is registered and compared against a behavioural model on every cycle, each of these faults is reported in the cycle in which it first appears.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_STROBE = 2'd1,
      SEQ_HOLD   = 2'd2
   } seq_state_t;
endpackage

// File: rtl/dac_word_slice.sv
module dac_word_slice #(
   parameter int IN_W      = 32,
   parameter int OUT_W     = 12,
   parameter int SLICE_MSB = 31
) (
   input  logic [IN_W-1:0]  word_in,
   output logic [OUT_W-1:0] slice_out
);
   localparam int SLICE_LSB = SLICE_MSB - OUT_W + 1;

   initial begin
      assert (OUT_W >= 1 && OUT_W <= IN_W) else $error("slice width out of range");
      assert (SLICE_MSB < IN_W && SLICE_LSB >= 0) else $error("slice position out of range");
   end

   generate
      if (OUT_W == IN_W) begin : g_full
         assign slice_out = word_in;
      end else begin : g_part
         logic unused_bits;
         assign slice_out   = word_in[SLICE_MSB:SLICE_LSB];
         assign unused_bits = ^word_in;
      end
   endgenerate
endmodule

// File: rtl/dac_strobe_fsm.sv
module dac_strobe_fsm
   import dac_seq_pkg::*;
#(
   parameter int WE_LOW = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic load,
   output logic cs_n,
   output logic we_n
);
   localparam int CNT_W = (WE_LOW > 1) ? $clog2(WE_LOW) : 1;
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WE_LOW - 1);

   initial begin
      assert (WE_LOW >= 1) else $error("write-enable low time must be at least one cycle");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;

   assign busy = (state != SEQ_IDLE);
   assign load = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
         cs_n  <= 1'b1;
         we_n  <= 1'b1;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state <= SEQ_STROBE;
                  cnt   <= CNT_INIT;
                  cs_n  <= 1'b0;
                  we_n  <= 1'b0;
               end
            end
            SEQ_STROBE: begin
               if (cnt == '0) begin
                  we_n  <= 1'b1;
                  state <= SEQ_HOLD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SEQ_HOLD: begin
               cs_n  <= 1'b1;
               state <= SEQ_IDLE;
            end
            default: begin
               state <= SEQ_IDLE;
               cs_n  <= 1'b1;
               we_n  <= 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/dac_ovr_track.sv
module dac_ovr_track (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic busy,
   output logic ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovr <= 1'b0;
      else if (strobe && busy)
         ovr <= 1'b1;
   end
endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq #(
   parameter int IN_W      = 32,
   parameter int DAC_W     = 12,
   parameter int SLICE_MSB = 31,
   parameter int WE_LOW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [IN_W-1:0]  smp_data,
   output logic [DAC_W-1:0] dac_bus,
   output logic             dac_cs_n,
   output logic             dac_we_n,
   output logic             ovr_flag
);
   logic [DAC_W-1:0] slice_w;
   logic             busy_w;
   logic             load_w;

   dac_word_slice #(
      .IN_W     (IN_W),
      .OUT_W    (DAC_W),
      .SLICE_MSB(SLICE_MSB)
   ) u_slice (
      .word_in  (smp_data),
      .slice_out(slice_w)
   );

   dac_strobe_fsm #(
      .WE_LOW(WE_LOW)
   ) u_fsm (
      .clk  (clk),
      .rst_n(rst_n),
      .start(smp_valid),
      .busy (busy_w),
      .load (load_w),
      .cs_n (dac_cs_n),
      .we_n (dac_we_n)
   );

   dac_ovr_track u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(smp_valid),
      .busy  (busy_w),
      .ovr   (ovr_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dac_bus <= '0;
      else if (load_w)
         dac_bus <= slice_w;
   end
endmodule

// File: rtl/dac_write_seq_chk.sv
module dac_write_seq_chk #(
   parameter int IN_W      = 32,
   parameter int DAC_W     = 12,
   parameter int SLICE_MSB = 31,
   parameter int WE_LOW    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic [IN_W-1:0]  smp_data,
   input logic [DAC_W-1:0] dac_bus,
   input logic             dac_cs_n,
   input logic             dac_we_n,
   input logic             ovr_flag
);
   localparam int LSB = SLICE_MSB - DAC_W + 1;

   logic [15:0] low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= '0;
      else if (!dac_we_n)
         low_cnt <= low_cnt + 16'd1;
      else
         low_cnt <= '0;
   end

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_cs_n && smp_valid) |=> (!dac_cs_n && !dac_we_n));

   p_slice_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_cs_n) |-> (dac_bus == $past(smp_data[SLICE_MSB:LSB])));

   p_we_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_we_n |-> !dac_cs_n);

   p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_we_n) |-> (low_cnt == 16'(WE_LOW)));

   p_cs_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_we_n) |=> $rose(dac_cs_n));

   p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_cs_n && !$past(dac_cs_n)) |-> $stable(dac_bus));

   p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_cs_n) |-> $past(smp_valid));

   p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_cs_n && smp_valid) |=> ovr_flag);

   p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |=> ovr_flag);
endmodule

bind dac_write_seq dac_write_seq_chk #(
   .IN_W     (IN_W),
   .DAC_W    (DAC_W),
   .SLICE_MSB(SLICE_MSB),
   .WE_LOW   (WE_LOW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_valid(smp_valid),
   .smp_data (smp_data),
   .dac_bus  (dac_bus),
   .dac_cs_n (dac_cs_n),
   .dac_we_n (dac_we_n),
   .ovr_flag (ovr_flag)
);

// File: tb/dac_write_seq_test.sv
module dac_write_seq_test;
   localparam int WE_LOW = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [31:0] smp_data = '0;
   logic [11:0] dac_bus;
   logic        dac_cs_n, dac_we_n, ovr_flag;

   int vecs = 0;
   int errs = 0;
   int cyc  = 0;
   bit done = 0;

   // behavioural reference
   int        m_t = 0;
   logic [11:0] m_bus = '0;
   logic      m_cs = 1'b1, m_we = 1'b1, m_ovr = 1'b0;

   always #2.5 clk = ~clk;

   dac_write_seq #(.WE_LOW(WE_LOW)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .dac_bus(dac_bus), .dac_cs_n(dac_cs_n), .dac_we_n(dac_we_n), .ovr_flag(ovr_flag)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_t = 0; m_bus = '0; m_cs = 1'b1; m_we = 1'b1; m_ovr = 1'b0;
      end else begin
         if (smp_valid && m_t != 0) m_ovr = 1'b1;
         if (m_t == 0) begin
            if (smp_valid) begin
               m_t = 1; m_cs = 1'b0; m_we = 1'b0; m_bus = 12'(smp_data >> 20);
            end
         end else begin
            m_t = m_t + 1;
            if (m_t == WE_LOW + 1) m_we = 1'b1;
            if (m_t == WE_LOW + 2) begin m_cs = 1'b1; m_t = 0; end
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         check("R2/R5 cs_n", 32'(dac_cs_n), 32'(m_cs));
         check("R4 we_n",    32'(dac_we_n), 32'(m_we));
         check("R3/R6 bus",  32'(dac_bus),  32'(m_bus));
         check("R8/R10 ovr", 32'(ovr_flag), 32'(m_ovr));
      end
      if (cyc > 100000 && !done) begin
         errs++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input logic [31:0] d);
      smp_valid = 1'b1; smp_data = d;
      @(negedge clk);
      smp_valid = 1'b0; smp_data = ~d;
   endtask

   initial begin
      logic [31:0] lf;
      idle(3);
      check("R1 cs_n in reset", 32'(dac_cs_n), 32'd1);
      check("R1 bus in reset",  32'(dac_bus),  32'd0);
      rst_n = 1'b1;
      idle(2);
      check("R1 we_n after reset", 32'(dac_we_n), 32'd1);
      check("R1 ovr after reset",  32'(ovr_flag), 32'd0);
      // R7: no valid, no write
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R7 idle cs_n", 32'(dac_cs_n), 32'd1);
      end
      // single writes with distinct patterns
      pulse(32'hFFF0_0000); idle(6);
      pulse(32'h000F_FFFF); idle(6);
      pulse(32'hA5A5_A5A5);
      check("R3 slice", 32'(dac_bus), 32'hA5A);
      idle(6);
      // R9 back-to-back: second strobe at first idle edge
      pulse(32'h1230_0000); idle(WE_LOW + 1);
      pulse(32'h4560_0000);
      check("R9 restart cs_n", 32'(dac_cs_n), 32'd0);
      check("R9 restart bus",  32'(dac_bus),  32'h456);
      idle(6);
      check("R8 ovr clear before drop", 32'(ovr_flag), 32'd0);
      // R8: strobe during write is dropped
      pulse(32'h7890_0000);
      pulse(32'hBCD0_0000);
      check("R8 bus kept", 32'(dac_bus), 32'h789);
      check("R8 ovr set",  32'(ovr_flag), 32'd1);
      idle(6);
      check("R8 no extra write", 32'(dac_cs_n), 32'd1);
      // R10: flag persists across later writes
      lf = 32'hACE1_2345;
      for (int i = 0; i < 20; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         pulse(lf);
         idle(i % 5);
      end
      idle(6);
      check("R10 ovr sticky", 32'(ovr_flag), 32'd1);
      // reset clears
      rst_n = 1'b0;
      idle(2);
      check("R1 ovr cleared", 32'(ovr_flag), 32'd0);
      check("R1 bus cleared", 32'(dac_bus), 32'd0);
      rst_n = 1'b1;
      idle(2);
      pulse(32'h0010_0000); idle(6);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule